// File: doc/BRIEF.md
# Single-Address DMA Channel with Configuration Screening

This block is one DMA channel that works in fly-by fashion: a peripheral (typically a flash controller) sits on the data path, and the channel drives only one memory address per beat. Software sets a transfer size, a direction, a source address, a signed source step and a byte count, then pulses `start`. In that same cycle the channel screens the settings. If any rule is broken, it raises a sticky error flag and issues no memory traffic. If the settings pass, it captures them and runs the beats: each beat is one request on a valid/ready memory port. After each beat the address moves by the step and the remaining count shrinks by the beat size.

Size codes map as follows. Codes 0–3 are single beats of 1, 2, 4 and 8 bytes. Codes 4–7 are bursts of 4, 8, 16 and 32 double words, which is 32, 64, 128 and 256 bytes. Direction codes map as follows: 0 is memory-to-peripheral (memory read), 1 is peripheral-to-memory (memory write), 2 is memory fill (memory write, no peripheral involved), and 3 is reserved. For a descending transfer, software programs the start address with its low alignment bits set to ones instead of zeros. The channel clears those bits before it puts the address on the bus.

Back-pressure rules on the memory port are these. Once `mem_req_valid` rises, it stays high, and address, size and write flag stay unchanged, until `mem_req_ready` is sampled high. A beat completes on a cycle where both are high. `mem_req_valid` never depends on `mem_req_ready` in the same cycle.

Top module: `sa_dma_chan`

## Requirements
- R1: `start` is acted on only while the channel is idle. A pulse while busy changes neither the error flag nor the running transfer. After an accepted start, `busy` is high from the next cycle.
- R2: For burst size codes 4–7, the step must be +8, 0 or -8. Any other step is a configuration error.
- R3: A zero step is legal only with direction 0. With direction 1 or 2 it is an error. Direction code 3 is always an error.
- R4: With a negative step, the low n bits of the source address must all be one. Here n is 0, 1, 2 or 3 for size codes 0, 1, 2 and 3–7.
- R5: With a zero or positive step, those same low n bits must all be zero.
- R6: The byte count must be nonzero and a whole multiple of the beat size (1, 2, 4, 8, 32, 64, 128 or 256 bytes for codes 0–7).
- R7: A rejected start sets `err_flag` on the next cycle. `busy` stays low and no memory request is made.
- R8: `err_flag` stays set until an `err_clr` pulse. A rejected start in the same cycle as `err_clr` leaves it set.
- R9: The bus address is the working address with its low n bits cleared. The working address starts at the programmed value. After each beat it moves by the step for codes 0–3, and by the step times (beat bytes / 8) for bursts.
- R10: Each completed beat subtracts the beat size from the count. The beat that reaches zero returns the channel to idle and sets `done`. `done` clears on the next accepted start.
- R11: `mem_req_valid` obeys the hold rules above. `mem_req_size` echoes the size code. `mem_req_write` is 0 for direction 0 and 1 for directions 1 and 2.
- R12: For directions 0 and 1, each beat is requested only after `periph_dreq` is seen high, and `periph_dack` pulses in the cycle the beat completes. Fill beats do not wait and never pulse `periph_dack`.
- R13: The destination address and destination step inputs have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; settings screened in this cycle |
| cfg_size | input | 3 | Transfer size code |
| cfg_dir | input | 2 | Direction code |
| cfg_src_addr | input | AW | Source (memory) start address |
| cfg_src_inc | input | IW | Signed source step |
| cfg_count | input | CW | Byte count |
| cfg_dst_addr | input | AW | Destination address (ignored) |
| cfg_dst_inc | input | IW | Destination step (ignored) |
| err_clr | input | 1 | Write-one-to-clear for the error flag |
| err_flag | output | 1 | Sticky configuration error |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last transfer completed |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_addr | output | AW | Aligned beat address |
| mem_req_size | output | 3 | Size code of the beat |
| mem_req_write | output | 1 | 1 = memory write, 0 = memory read |
| periph_dreq | input | 1 | Peripheral ready for a beat |
| periph_dack | output | 1 | Beat completed toward the peripheral |

## Verification
The screening logic is driven from a table of settings that covers every size class against ascending, zero and descending steps and all four direction codes. The table pairs each legal case with a near miss that breaks exactly one rule: a single wrong low address bit, a burst step of 16 or 4, a count off by one beat, or a zero step in the wrong direction. This shows that each rule rejects on its own and does not merely follow a neighbouring rule. Legal rows run to completion, and every bus address is compared against the expected walk. Descending rows with complemented low bits show that the bits are cleared on the bus and that the step is scaled for bursts. Directed cases hold `mem_req_ready` low, hold `periph_dreq` low, pulse `start` during a transfer, and collide `err_clr` with a rejected start.

// File: rtl/sa_dma_pkg.sv
package sa_dma_pkg;

  localparam logic [1:0] DIR_M2P  = 2'd0;
  localparam logic [1:0] DIR_P2M  = 2'd1;
  localparam logic [1:0] DIR_FILL = 2'd2;
  localparam logic [1:0] DIR_RSVD = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_REQ  = 2'd2
  } chan_st_e;

  // log2 of the beat size in bytes: codes 0..3 -> 0..3, codes 4..7 -> 5..8
  function automatic logic [3:0] beat_log2(input logic [2:0] code);
    return code[2] ? ({1'b0, code} + 4'd1) : {1'b0, code};
  endfunction

  // number of low address bits governed by the size
  function automatic logic [1:0] align_bits(input logic [2:0] code);
    return code[2] ? 2'd3 : code[1:0];
  endfunction

  function automatic logic [2:0] align_mask(input logic [2:0] code);
    logic [2:0] m;
    case (align_bits(code))
      2'd0:    m = 3'b000;
      2'd1:    m = 3'b001;
      2'd2:    m = 3'b011;
      default: m = 3'b111;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/sa_dma_cfg_check.sv
module sa_dma_cfg_check
  import sa_dma_pkg::*;
#(
  parameter int CW = 16,
  parameter int IW = 8
) (
  input  logic [2:0]    size_code,
  input  logic [1:0]    dir,
  input  logic [2:0]    addr_lo,
  input  logic [IW-1:0] inc,
  input  logic [CW-1:0] count,
  output logic          cfg_ok
);

  localparam logic [IW-1:0] INC_UP8 = IW'(8);
  localparam logic [IW-1:0] INC_DN8 = ~INC_UP8 + IW'(1);

  logic [2:0]    amask;
  logic [CW-1:0] cmask;
  logic          inc_neg, inc_zero;
  logic          burst_ok, zero_ok, addr_ok, cnt_ok, dir_ok;

  always_comb begin
    amask    = align_mask(size_code);
    cmask    = (CW'(1) << beat_log2(size_code)) - CW'(1);
    inc_neg  = inc[IW-1];
    inc_zero = (inc == '0);
    // bursts only accept a double-word step or none
    burst_ok = !size_code[2] || inc_zero || (inc == INC_UP8) || (inc == INC_DN8);
    // a fixed address only makes sense when memory is read
    zero_ok  = !inc_zero || (dir == DIR_M2P);
    // descending starts carry ones in the alignment bits
    addr_ok  = inc_neg ? ((addr_lo & amask) == amask)
                       : ((addr_lo & amask) == 3'b000);
    cnt_ok   = (count != '0) && ((count & cmask) == '0);
    dir_ok   = (dir != DIR_RSVD);
    cfg_ok   = burst_ok && zero_ok && addr_ok && cnt_ok && dir_ok;
  end

endmodule

// File: rtl/sa_dma_addr_cnt.sv
module sa_dma_addr_cnt
  import sa_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [IW-1:0] ld_inc,
  input  logic [CW-1:0] ld_count,
  input  logic [2:0]    ld_size,
  input  logic [1:0]    ld_dir,
  output logic [AW-1:0] bus_addr,
  output logic [2:0]    size_q,
  output logic [1:0]    dir_q,
  output logic          last
);

  localparam int PADW = AW - IW;

  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] inc_q;
  logic [AW-1:0] step;
  logic [CW-1:0] beat_bytes;

  always_comb begin
    beat_bytes = CW'(1) << beat_log2(size_q);
    step       = {{PADW{inc_q[IW-1]}}, inc_q};
    if (size_q[2]) begin
      step = step << (beat_log2(size_q) - 4'd3);
    end
    bus_addr = addr_q & ~{{(AW-3){1'b0}}, align_mask(size_q)};
    last     = (cnt_q == beat_bytes);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
      inc_q  <= '0;
      size_q <= '0;
      dir_q  <= DIR_M2P;
    end else if (load) begin
      addr_q <= ld_addr;
      cnt_q  <= ld_count;
      inc_q  <= ld_inc;
      size_q <= ld_size;
      dir_q  <= ld_dir;
    end else if (step_en) begin
      addr_q <= addr_q + step;
      cnt_q  <= cnt_q - beat_bytes;
    end
  end

endmodule

// File: rtl/sa_dma_ctrl.sv
module sa_dma_ctrl
  import sa_dma_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       cfg_ok,
  input  logic       err_clr,
  input  logic       periph_dreq,
  input  logic       mem_req_ready,
  input  logic       last,
  input  logic [1:0] dir_q,
  output logic       load,
  output logic       req_valid,
  output logic       fire,
  output logic       busy,
  output logic       done,
  output logic       err_flag
);

  chan_st_e st_q, st_d;
  logic     idle, reject, go;

  always_comb begin
    idle      = (st_q == ST_IDLE);
    load      = start && idle && cfg_ok;
    reject    = start && idle && !cfg_ok;
    req_valid = (st_q == ST_REQ);
    fire      = req_valid && mem_req_ready;
    busy      = !idle;
    go        = (dir_q == DIR_FILL) || periph_dreq;
    st_d      = st_q;
    case (st_q)
      ST_IDLE: if (load) st_d = ST_WAIT;
      ST_WAIT: if (go)   st_d = ST_REQ;
      ST_REQ:  if (fire) st_d = last ? ST_IDLE : ST_WAIT;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      done     <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      st_q <= st_d;
      if (load) begin
        done <= 1'b0;
      end else if (fire && last) begin
        done <= 1'b1;
      end
      if (reject) begin
        err_flag <= 1'b1;
      end else if (err_clr) begin
        err_flag <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/sa_dma_chan.sv
module sa_dma_chan
  import sa_dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int IW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    cfg_size,
  input  logic [1:0]    cfg_dir,
  input  logic [AW-1:0] cfg_src_addr,
  input  logic [IW-1:0] cfg_src_inc,
  input  logic [CW-1:0] cfg_count,
  input  logic [AW-1:0] cfg_dst_addr,
  input  logic [IW-1:0] cfg_dst_inc,
  input  logic          err_clr,
  output logic          err_flag,
  output logic          busy,
  output logic          done,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  output logic [2:0]    mem_req_size,
  output logic          mem_req_write,
  input  logic          periph_dreq,
  output logic          periph_dack
);

  logic       cfg_ok, load, fire, last;
  logic [1:0] dir_q;

  // destination fields play no part in fly-by transfers
  logic unused_dst;
  assign unused_dst = ^{cfg_dst_addr, cfg_dst_inc};

  sa_dma_cfg_check #(.CW(CW), .IW(IW)) chk_cfg_i (
    .size_code (cfg_size),
    .dir       (cfg_dir),
    .addr_lo   (cfg_src_addr[2:0]),
    .inc       (cfg_src_inc),
    .count     (cfg_count),
    .cfg_ok    (cfg_ok)
  );

  sa_dma_addr_cnt #(.AW(AW), .CW(CW), .IW(IW)) dp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .step_en  (fire),
    .ld_addr  (cfg_src_addr),
    .ld_inc   (cfg_src_inc),
    .ld_count (cfg_count),
    .ld_size  (cfg_size),
    .ld_dir   (cfg_dir),
    .bus_addr (mem_req_addr),
    .size_q   (mem_req_size),
    .dir_q    (dir_q),
    .last     (last)
  );

  sa_dma_ctrl ctrl_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .cfg_ok        (cfg_ok),
    .err_clr       (err_clr),
    .periph_dreq   (periph_dreq),
    .mem_req_ready (mem_req_ready),
    .last          (last),
    .dir_q         (dir_q),
    .load          (load),
    .req_valid     (mem_req_valid),
    .fire          (fire),
    .busy          (busy),
    .done          (done),
    .err_flag      (err_flag)
  );

  assign mem_req_write = (dir_q != DIR_M2P);
  assign periph_dack   = fire && (dir_q != DIR_FILL);

endmodule

// File: rtl/sa_dma_chan_chk.sv
module sa_dma_chan_chk #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int IW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [2:0]    cfg_size,
  input logic [1:0]    cfg_dir,
  input logic [AW-1:0] cfg_src_addr,
  input logic [IW-1:0] cfg_src_inc,
  input logic [CW-1:0] cfg_count,
  input logic [AW-1:0] cfg_dst_addr,
  input logic [IW-1:0] cfg_dst_inc,
  input logic          err_clr,
  input logic          err_flag,
  input logic          busy,
  input logic          done,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic [AW-1:0] mem_req_addr,
  input logic [2:0]    mem_req_size,
  input logic          mem_req_write,
  input logic          periph_dreq,
  input logic          periph_dack
);

  logic unused_chk;
  assign unused_chk = ^{start, cfg_size, cfg_dir, cfg_src_addr, cfg_src_inc, cfg_count,
                        cfg_dst_addr, cfg_dst_inc, periph_dreq};

  a_r11_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_size) && $stable(mem_req_write));

  a_r7_reject_no_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> !busy && !mem_req_valid);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !err_clr |=> err_flag);

  a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r1_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  a_r12_dack_beat: assert property (@(posedge clk) disable iff (!rst_n)
    periph_dack |-> mem_req_valid && mem_req_ready);

endmodule

bind sa_dma_chan sa_dma_chan_chk #(.AW(AW), .CW(CW), .IW(IW)) sva_i (.*);

// File: tb/sa_dma_chan_tb_top.sv
module sa_dma_chan_tb_top;

  typedef struct packed {
    logic [2:0]  size;
    logic [1:0]  dir;
    logic [31:0] addr;
    logic [7:0]  inc;
    logic [15:0] cnt;
    logic        ok;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 2'd0, 32'h0001_0003, 8'h01, 16'd3,   1'b1, 4'd5},  // R5 byte: no alignment
    '{3'd0, 2'd1, 32'h0001_0005, 8'hFF, 16'd2,   1'b1, 4'd4},  // R4 byte descending
    '{3'd1, 2'd0, 32'h0001_0000, 8'h02, 16'd4,   1'b1, 4'd5},  // R5
    '{3'd1, 2'd0, 32'h0001_0001, 8'hFE, 16'd4,   1'b1, 4'd4},  // R4 complemented bit
    '{3'd1, 2'd1, 32'h0001_0001, 8'h02, 16'd4,   1'b0, 4'd5},  // R5 misaligned
    '{3'd2, 2'd1, 32'h0001_0003, 8'hFC, 16'd8,   1'b1, 4'd4},  // R4
    '{3'd2, 2'd1, 32'h0001_0001, 8'hFC, 16'd8,   1'b0, 4'd4},  // R4 one bit wrong
    '{3'd2, 2'd0, 32'h0001_0004, 8'h04, 16'd6,   1'b0, 4'd6},  // R6 count misaligned
    '{3'd3, 2'd2, 32'h0001_0000, 8'h08, 16'd16,  1'b1, 4'd12}, // R12 fill
    '{3'd3, 2'd0, 32'h0001_0007, 8'hF8, 16'd8,   1'b1, 4'd9},  // R9 cleared bits
    '{3'd3, 2'd0, 32'h0001_0003, 8'hF8, 16'd8,   1'b0, 4'd4},  // R4
    '{3'd4, 2'd0, 32'h0001_0000, 8'h08, 16'd64,  1'b1, 4'd9},  // R9 burst scaled
    '{3'd4, 2'd0, 32'h0001_0000, 8'h10, 16'd32,  1'b0, 4'd2},  // R2 step 16
    '{3'd5, 2'd0, 32'h0001_0007, 8'hF8, 16'd64,  1'b1, 4'd9},  // R9 burst descending
    '{3'd4, 2'd0, 32'h0001_0000, 8'h00, 16'd32,  1'b1, 4'd3},  // R3 zero legal
    '{3'd4, 2'd1, 32'h0001_0000, 8'h00, 16'd32,  1'b0, 4'd3},  // R3
    '{3'd3, 2'd2, 32'h0001_0000, 8'h00, 16'd8,   1'b0, 4'd3},  // R3 fill zero
    '{3'd0, 2'd3, 32'h0001_0000, 8'h01, 16'd1,   1'b0, 4'd3},  // R3 reserved dir
    '{3'd2, 2'd0, 32'h0001_0000, 8'h04, 16'd0,   1'b0, 4'd6},  // R6 zero count
    '{3'd7, 2'd1, 32'h0001_0007, 8'hF8, 16'd512, 1'b1, 4'd10}, // R10 two big beats
    '{3'd6, 2'd0, 32'h0001_0000, 8'h04, 16'd128, 1'b0, 4'd2},  // R2 step 4
    '{3'd7, 2'd0, 32'h0001_0000, 8'h08, 16'd128, 1'b0, 4'd6}   // R6 not whole beat
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  cfg_size = '0;
  logic [1:0]  cfg_dir = '0;
  logic [31:0] cfg_src_addr = '0;
  logic [7:0]  cfg_src_inc = '0;
  logic [15:0] cfg_count = '0;
  logic [31:0] cfg_dst_addr = '0;
  logic [7:0]  cfg_dst_inc = '0;
  logic        err_clr = 1'b0;
  logic        err_flag, busy, done;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic [2:0]  mem_req_size;
  logic        mem_req_write;
  logic        periph_dreq = 1'b1;
  logic        periph_dack;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  sa_dma_chan dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_size(cfg_size), .cfg_dir(cfg_dir), .cfg_src_addr(cfg_src_addr),
    .cfg_src_inc(cfg_src_inc), .cfg_count(cfg_count),
    .cfg_dst_addr(cfg_dst_addr), .cfg_dst_inc(cfg_dst_inc),
    .err_clr(err_clr), .err_flag(err_flag), .busy(busy), .done(done),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_req_size(mem_req_size),
    .mem_req_write(mem_req_write), .periph_dreq(periph_dreq),
    .periph_dack(periph_dack)
  );

  task automatic chk(input bit cond, input string req, input longint act, input longint exp);
    n_checks++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic int log2b(input logic [2:0] s);
    return (s >= 3'd4) ? int'(s) + 1 : int'(s);
  endfunction

  task automatic set_cfg(input logic [2:0] s, input logic [1:0] d, input logic [31:0] a,
                         input logic [7:0] i, input logic [15:0] c);
    cfg_size = s; cfg_dir = d; cfg_src_addr = a; cfg_src_inc = i; cfg_count = c;
    cfg_dst_addr = $urandom;   // R13: destination fields are noise
    cfg_dst_inc  = 8'($urandom);
  endtask

  task automatic drain(output int beats);
    beats = 0;
    for (int k = 0; k < 2000; k++) begin
      if (mem_req_valid && mem_req_ready) beats++;
      tick();
      if (done) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int beats;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(!busy && !done && !err_flag && !mem_req_valid, "R1 reset state",
        {busy, done, err_flag, mem_req_valid}, 0);

    // configuration table walk (R2..R6, R9, R10, R12, R13)
    for (int v = 0; v < NV; v++) begin
      vec_t e;
      string tag;
      int lg, nb, bad;
      logic [31:0] exp_a, msk, stepv;
      e = VEC[v];
      tag = $sformatf("R%0d vec %0d", e.req, v);
      lg = log2b(e.size);
      mem_req_ready = 1'b1;
      periph_dreq = 1'b1;
      set_cfg(e.size, e.dir, e.addr, e.inc, e.cnt);
      start = 1'b1;
      tick();
      start = 1'b0;
      if (!e.ok) begin
        chk(err_flag && !busy, {tag, " R7 reject"}, {err_flag, busy}, 2'b10);
        bad = 0;
        for (int k = 0; k < 5; k++) begin
          if (mem_req_valid || busy) bad++;
          tick();
        end
        chk(bad == 0, {tag, " R7 no request"}, bad, 0);
        err_clr = 1'b1;
        tick();
        err_clr = 1'b0;
        chk(!err_flag, {tag, " R8 clear"}, err_flag, 0);
      end else begin
        chk(busy && !err_flag, {tag, " R1 accept"}, {busy, err_flag}, 2'b10);
        msk   = (e.size >= 3'd3) ? 32'h7 : ((32'h1 << e.size) - 1);
        stepv = {{24{e.inc[7]}}, e.inc};
        if (e.size >= 3'd4) stepv = stepv << (lg - 3);
        exp_a = e.addr;
        nb = 0;
        for (int k = 0; k < 2000; k++) begin
          if (mem_req_valid) begin
            chk(mem_req_addr == (exp_a & ~msk), {tag, " R9 address"}, mem_req_addr, exp_a & ~msk);
            chk(mem_req_write == (e.dir != 2'd0) && mem_req_size == e.size,
                {tag, " R11 write/size"}, {mem_req_write, mem_req_size}, {e.dir != 2'd0, e.size});
            chk(periph_dack == (e.dir != 2'd2), {tag, " R12 dack"}, periph_dack, e.dir != 2'd2);
            exp_a = exp_a + stepv;
            nb++;
          end
          tick();
          if (done) break;
        end
        chk(nb == (int'(e.cnt) >> lg), {tag, " R10 beats"}, nb, int'(e.cnt) >> lg);
        chk(done && !busy, {tag, " R10 done"}, {done, busy}, 2'b10);
      end
    end

    // R11 back-pressure
    set_cfg(3'd3, 2'd0, 32'h2000, 8'h08, 16'd16);
    mem_req_ready = 1'b0;
    start = 1'b1; tick(); start = 1'b0;
    chk(!done, "R10 done cleared on start", done, 0);
    tick();
    for (int k = 0; k < 3; k++) begin
      chk(mem_req_valid && mem_req_addr == 32'h2000 && !periph_dack, "R11 hold under stall",
          {mem_req_valid, mem_req_addr}, {1'b1, 32'h2000});
      tick();
    end
    mem_req_ready = 1'b1;
    #1;
    chk(periph_dack, "R12 dack on accept", periph_dack, 1);
    drain(beats);
    chk(beats == 2, "R11 beats after stall", beats, 2);

    // R12 peripheral gating
    set_cfg(3'd2, 2'd1, 32'h3000, 8'h04, 16'd4);
    periph_dreq = 1'b0;
    start = 1'b1; tick(); start = 1'b0;
    beats = 0;
    for (int k = 0; k < 4; k++) begin
      if (mem_req_valid) beats++;
      tick();
    end
    chk(beats == 0 && busy, "R12 waits for dreq", beats, 0);
    periph_dreq = 1'b1;
    tick();
    chk(mem_req_valid && mem_req_write && periph_dack, "R12 request after dreq",
        {mem_req_valid, mem_req_write, periph_dack}, 3'b111);
    tick();
    chk(done && !busy, "R10 single beat done", {done, busy}, 2'b10);

    // R1 start while busy is ignored
    set_cfg(3'd0, 2'd0, 32'h4000, 8'h01, 16'd2);
    start = 1'b1; tick(); start = 1'b0;
    set_cfg(3'd0, 2'd3, 32'h4000, 8'h01, 16'd1);
    start = 1'b1; tick(); start = 1'b0;
    chk(!err_flag && busy, "R1 busy start ignored", {err_flag, busy}, 2'b01);
    drain(beats);
    chk(beats == 2, "R1 transfer unchanged", beats, 2);

    // R8 sticky flag and collision with clear
    start = 1'b1; tick(); start = 1'b0;
    tick(); tick(); tick();
    chk(err_flag, "R8 sticky", err_flag, 1);
    start = 1'b1; err_clr = 1'b1; tick(); start = 1'b0; err_clr = 1'b0;
    chk(err_flag, "R8 reject beats clear", err_flag, 1);
    err_clr = 1'b1; tick(); err_clr = 1'b0;
    chk(!err_flag, "R8 clear", err_flag, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule